// File: doc/BRIEF.md
# Two-Level Radix-8 Significand Shifter

This block moves a 53-bit floating-point significand by any distance from 0 to 53 positions, to the left or to the right. It serves both the alignment step ahead of an add or subtract and the normalization step after it. A mode input selects a logical shift or a circular rotate. In logical mode the vacated positions take zeros. In rotate mode the bits that leave one end come back in at the other.

The distance is handled by two cascaded selection levels. The fine level moves the word by 0 to 7 places under the three low bits of the amount. The coarse level then moves it by a multiple of eight (0, 8, ... 48) under the remaining upper bits. Each level is a one-of-eight choice per output bit, so every bit has a short, balanced fan-out. An optional output register closes the path for timing. With the default parameters it is present, and the result appears one clock after the inputs.

Amounts from 54 to 63 can be encoded on the 6-bit amount input. In shift mode they, like 53 itself, clear the word. In rotate mode they wrap modulo 53.

Top module: `bshift_r8`

## Requirements
- R1: Logical left shift (dir_left=1, rotate=0) by an amount k from 0 to 52 gives data_in << k truncated to 53 bits, with zeros in the k low positions.
- R2: Logical right shift (dir_left=0, rotate=0) by k from 0 to 52 gives data_in >> k, with zeros in the k high positions.
- R3: Rotate left (dir_left=1, rotate=1) by k from 1 to 52 moves bit i to position (i+k) mod 53, so no bit is lost.
- R4: Rotate right (dir_left=0, rotate=1) by k from 1 to 52 moves bit i to position (i-k) mod 53, so no bit is lost.
- R5: In shift mode any amount from 53 to 63 gives an all-zero result, in either direction.
- R6: In rotate mode an amount from 53 to 63 acts as the amount minus 53, so 53 returns the input unchanged.
- R7: An amount of zero returns data_in unchanged in all four direction and mode combinations.
- R8: With the output register enabled (the default), data_out reflects the inputs sampled at the previous rising clock edge, and it is all zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| data_in | input | 53 | Significand to be moved |
| amount | input | 6 | Distance in bit positions, 0 to 63 |
| dir_left | input | 1 | 1 moves toward the MSB, 0 moves toward the LSB |
| rotate | input | 1 | 1 selects circular rotate, 0 selects logical shift with zero fill |
| data_out | output | 53 | Moved significand |

## Verification
The datapath keeps no state between operations, so a fault in either level or in the amount reduction shows up at data_out in the very operation that exercises it. With the default register that is one clock later. Errors confined to one level have recognisable signatures. A fine-level error shows as a result off by one to seven places for amounts with the same low three bits. A coarse-level error shows as a result off by a multiple of eight. A fill or wrap error shows as stray ones in positions that should be zero, or as lost bits in rotate mode. Sweeping every amount in every direction and mode, with several bit patterns, exposes each of these within one cycle of the offending input.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   // default significand width and fine-level select width
   localparam int DEF_SIG_W  = 53;
   localparam int DEF_FINE_W = 3;

   // control bundle passed to each selection level
   typedef struct packed {
      logic to_msb;
      logic circular;
   } move_ctrl_t;

endpackage

// File: rtl/bshift_amt_prep.sv
module bshift_amt_prep #(
   parameter int W      = 53,
   parameter int AMT_W  = 6,
   parameter int FINE_W = 3,
   localparam int COARSE_W = AMT_W - FINE_W
) (
   input  logic [AMT_W-1:0]    amt_raw,
   input  logic                circular,
   output logic [FINE_W-1:0]   fine_sel,
   output logic [COARSE_W-1:0] coarse_sel
);

   localparam logic [AMT_W-1:0] WRAP = AMT_W'(W);

   logic [AMT_W-1:0] amt_eff;

   // rotate distances wrap modulo W; one subtraction suffices because the
   // top checks that the largest encodable amount is below 2*W
   always_comb begin
      if (circular && (amt_raw >= WRAP)) amt_eff = amt_raw - WRAP;
      else                               amt_eff = amt_raw;
   end

   assign fine_sel   = amt_eff[FINE_W-1:0];
   assign coarse_sel = amt_eff[AMT_W-1:FINE_W];

endmodule

// File: rtl/bshift_level.sv
module bshift_level
   import bshift_pkg::*;
#(
   parameter int W    = 53,
   parameter int SELW = 3,
   parameter int STEP = 1,
   localparam int NSEL = 2 ** SELW
) (
   input  logic [W-1:0]    din,
   input  logic [SELW-1:0] sel,
   input  move_ctrl_t      ctrl,
   output logic [W-1:0]    dout
);

   // one candidate word per selectable distance sel*STEP
   logic [NSEL-1:0][W-1:0] cand;

   for (genvar j = 0; j < NSEL; j++) begin : g_dist
      localparam int K = j * STEP;
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic up_bit;
         logic dn_bit;
         // toward MSB: source is i-K, wrapped source i-K+W
         if (i >= K) begin : g_up_in
            assign up_bit = din[i-K];
         end else if (i - K + W >= 0) begin : g_up_wrap
            assign up_bit = ctrl.circular & din[i-K+W];
         end else begin : g_up_zero
            assign up_bit = 1'b0;
         end
         // toward LSB: source is i+K, wrapped source i+K-W
         if (i + K < W) begin : g_dn_in
            assign dn_bit = din[i+K];
         end else if (i + K - W < W) begin : g_dn_wrap
            assign dn_bit = ctrl.circular & din[i+K-W];
         end else begin : g_dn_zero
            assign dn_bit = 1'b0;
         end
         assign cand[j][i] = ctrl.to_msb ? up_bit : dn_bit;
      end
   end

   assign dout = cand[sel];

endmodule

// File: rtl/bshift_r8.sv
module bshift_r8
   import bshift_pkg::*;
#(
   parameter int W       = DEF_SIG_W,
   parameter int AMT_W   = $clog2(W + 1),
   parameter int FINE_W  = DEF_FINE_W,
   parameter int OUT_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     data_in,
   input  logic [AMT_W-1:0] amount,
   input  logic             dir_left,
   input  logic             rotate,
   output logic [W-1:0]     data_out
);

   localparam int COARSE_W = AMT_W - FINE_W;
   localparam int FINE_N   = 2 ** FINE_W;

   // elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("bshift_r8: W must be at least 2");
   end
   if (FINE_W < 1 || FINE_W >= AMT_W) begin : g_bad_fine
      $error("bshift_r8: FINE_W must lie between 1 and AMT_W-1");
   end
   if ((2 ** AMT_W) - 1 < W) begin : g_bad_amt
      $error("bshift_r8: AMT_W cannot encode a full-width move");
   end
   if ((2 ** AMT_W) > 2 * W) begin : g_bad_wrap
      $error("bshift_r8: AMT_W too wide for single-step rotate wrap");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
      $error("bshift_r8: OUT_REG must be 0 or 1");
   end

   move_ctrl_t          ctrl;
   logic [FINE_W-1:0]   fine_sel;
   logic [COARSE_W-1:0] coarse_sel;
   logic [W-1:0]        fine_out;
   logic [W-1:0]        coarse_out;

   assign ctrl.to_msb   = dir_left;
   assign ctrl.circular = rotate;

   bshift_amt_prep #(
      .W      (W),
      .AMT_W  (AMT_W),
      .FINE_W (FINE_W)
   ) u_prep (
      .amt_raw    (amount),
      .circular   (rotate),
      .fine_sel   (fine_sel),
      .coarse_sel (coarse_sel)
   );

   bshift_level #(
      .W    (W),
      .SELW (FINE_W),
      .STEP (1)
   ) u_fine (
      .din  (data_in),
      .sel  (fine_sel),
      .ctrl (ctrl),
      .dout (fine_out)
   );

   bshift_level #(
      .W    (W),
      .SELW (COARSE_W),
      .STEP (FINE_N)
   ) u_coarse (
      .din  (fine_out),
      .sel  (coarse_sel),
      .ctrl (ctrl),
      .dout (coarse_out)
   );

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) data_out <= '0;
         else        data_out <= coarse_out;
      end
   end else begin : g_comb
      assign data_out = coarse_out;
   end

endmodule

// File: rtl/bshift_r8_chk.sv
module bshift_r8_chk #(
   parameter int W     = 53,
   parameter int AMT_W = 6,
   parameter int LAT   = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [W-1:0]     data_in,
   input logic [AMT_W-1:0] amount,
   input logic             dir_left,
   input logic             rotate,
   input logic [W-1:0]     data_out
);

   logic             armed;
   logic [W-1:0]     q_in;
   logic [AMT_W-1:0] q_amt;
   logic             q_left;
   logic             q_rot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // align the operands with the output they produced
   if (LAT == 1) begin : g_lat
      always_ff @(posedge clk) begin
         q_in   <= data_in;
         q_amt  <= amount;
         q_left <= dir_left;
         q_rot  <= rotate;
      end
   end else begin : g_nolat
      assign q_in   = data_in;
      assign q_amt  = amount;
      assign q_left = dir_left;
      assign q_rot  = rotate;
   end

   function automatic logic [W-1:0] low_mask(input logic [AMT_W-1:0] k);
      logic [W:0] one;
      one = (W+1)'(1);
      return W'((one << k) - (W+1)'(1));
   endfunction

   // R1: zeros enter at the LSB end on a logical left move
   p_left_fill_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!q_rot && q_left && int'(q_amt) < W) |-> ((data_out & low_mask(q_amt)) == '0));

   // R2: zeros enter at the MSB end on a logical right move
   p_right_fill_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!q_rot && !q_left && q_amt != '0 && int'(q_amt) < W) |->
      ((data_out >> (W - int'(q_amt))) == '0));

   // R3 and R4: a rotate keeps every set bit
   p_rot_count_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      q_rot |-> ($countones(data_out) == $countones(q_in)));

   // R5: full-width or larger logical moves clear the word
   p_shift_over_zero_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!q_rot && int'(q_amt) >= W) |-> (data_out == '0));

   // R6: a rotate by exactly W is the identity
   p_rot_full_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (q_rot && int'(q_amt) == W) |-> (data_out == q_in));

   // R7: zero distance passes the word through
   p_zero_amt_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (q_amt == '0) |-> (data_out == q_in));

endmodule

bind bshift_r8 bshift_r8_chk #(
   .W     (W),
   .AMT_W (AMT_W),
   .LAT   (OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .data_in  (data_in),
   .amount   (amount),
   .dir_left (dir_left),
   .rotate   (rotate),
   .data_out (data_out)
);

// File: tb/bshift_r8_bench.sv
`timescale 1ns/1ps
module bshift_r8_bench;

   localparam int W      = 53;
   localparam int AMT_W  = 6;
   localparam int MAX_CY = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [W-1:0]     data_in = '0;
   logic [AMT_W-1:0] amount = '0;
   logic             dir_left = 1'b0;
   logic             rotate = 1'b0;
   logic [W-1:0]     data_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #10 clk = ~clk;

   bshift_r8 u_bshift_r8 (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_in  (data_in),
      .amount   (amount),
      .dir_left (dir_left),
      .rotate   (rotate),
      .data_out (data_out)
   );

   // behavioural reference from the requirements
   function automatic logic [W-1:0] model(input logic [W-1:0] v, input int k,
                                          input bit left, input bit rot);
      int r;
      if (!rot) return left ? (v << k) : (v >> k);
      r = k % W;
      if (r == 0) return v;
      return left ? ((v << r) | (v >> (W - r))) : ((v >> r) | (v << (W - r)));
   endfunction

   function automatic string req_of(input int k, input bit left, input bit rot);
      if (k == 0) return "R7";
      if (rot)    return (k >= W) ? "R6" : (left ? "R3" : "R4");
      return (k >= W) ? "R5" : (left ? "R1" : "R2");
   endfunction

   // compare the oldest expectation with the port value
   task automatic check_out();
      logic [W-1:0] e;
      string t;
      if (exp_q.size() == 0) return;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (data_out !== e) begin
         errors++;
         $display("FAIL %s (R8 latency) got=%h exp=%h", t, data_out, e);
      end
   endtask

   // drive one operation at the falling edge, check the previous one
   task automatic apply(input logic [W-1:0] v, input int k, input bit left, input bit rot);
      @(negedge clk);
      check_out();
      data_in  = v;
      amount   = AMT_W'(k);
      dir_left = left;
      rotate   = rot;
      exp_q.push_back(model(v, k, left, rot));
      tag_q.push_back(req_of(k, left, rot));
   endtask

   task automatic sweep(input logic [W-1:0] v);
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 64; k++) begin
            apply(v, k, m[0], m[1]);
         end
      end
   endtask

   initial begin
      // R8: output held at zero during reset despite live inputs
      data_in = {W{1'b1}};
      amount  = 6'd5;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (data_out !== '0) begin
         errors++;
         $display("FAIL R8 reset got=%h exp=%h", data_out, {W{1'b0}});
      end
      rst_n = 1'b1;

      sweep(W'(1));                           // single LSB
      sweep({1'b1, {(W-1){1'b0}}});           // single MSB
      sweep({W{1'b1}});                       // all ones
      sweep({27{2'b10}} >> 1);                // alternating
      sweep(53'h0F0_0F0F_A5C3_1E2D);          // mixed
      for (int n = 0; n < 400; n++) begin     // scattered operations
         apply({$urandom, $urandom}, int'($urandom_range(0, 63)),
               1'($urandom), 1'($urandom));
      end
      @(negedge clk);
      check_out();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (MAX_CY) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog got=timeout exp=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule